// File: doc/BRIEF.md
# Snooping Posted-Write Address Buffer

This block is the address half of a shared buffer between a processor's local bus and a memory bus. Writes that need no burst are posted into a small queue so the processor can start its next cycle at once. A write to the same address as the newest queued write is folded into that entry when the two sets of byte lanes are disjoint, so repeated partial writes do not fill the queue. Cache evictions and line fills each park one line start address. The memory side produces the remaining addresses of the burst itself.

Reads win the memory bus. A read that finds the bus free goes out in the same cycle. Otherwise it waits in a one-entry holding register. Before a read goes to memory, its line is compared with the parked eviction and line-fill addresses. On a match the block raises a hit, so the data can be returned through the internal bypass path and no stale copy is fetched. A small decoder also turns the local bus status into the write-back, line-feed and owned cycle indications.

Top module: `snoop_post_addr_buf`

## Requirements
- R1: After reset no memory request is offered (`mem_valid` low), and `cpu_wr_ready`, `rd_ready`, `evict_ready` and `fill_ready` are all high.
- R2: Posted writes reach the memory bus in arrival order, with kind code 3, their own address and their byte enables.
- R3: A posted write to the same address as the newest queued entry merges into that entry when their byte enables share no set bit. The entry's enables become the OR of both, and no entry is added. This holds unless that entry is the only one and is leaving the queue in the same cycle.
- R4: A posted write with a different address, or with any byte enable overlapping the newest entry's, takes a new entry.
- R5: The posted queue holds DEPTH entries (default 4). While it is full, `cpu_wr_ready` is low.
- R6: The eviction store and the line-fill store each hold one line start address, with the offset bits below the line size cleared. Each one's ready is low while it is occupied. Each issues once, with kind code 1 (eviction) or 2 (line fill) and all byte enables set.
- R7: Memory bus priority is: held read, then new read, then eviction, then line fill, then posted write.
- R8: A read that is not a hit goes to the bus in the same cycle, with kind code 0, when the bus is free and no read is held. Otherwise its address is held, with `rd_ready` low, until the bus accepts it.
- R9: A read whose line equals a parked eviction or line-fill line raises `rd_hit` in that cycle and is never sent to memory.
- R10: `cyc_wb` = (read AND coherence-with-owned-state AND intervene) OR (write AND line Modified). `cyc_lf` = intervene. `cyc_o3` = read AND coherence-with-owned-state AND intervene.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_valid | input | 1 | Posted write request |
| cpu_wr_addr | input | AW | Posted write address |
| cpu_wr_be | input | BEW | Posted write byte enables |
| cpu_wr_ready | output | 1 | Posted write accepted; low stalls the CPU |
| evict_load | input | 1 | Park an eviction address |
| evict_addr | input | AW | Eviction address (any byte in the line) |
| evict_ready | output | 1 | Eviction store empty |
| fill_load | input | 1 | Park a line-fill address |
| fill_addr | input | AW | Line-fill address (any byte in the line) |
| fill_ready | output | 1 | Line-fill store empty |
| rd_req | input | 1 | Read needing memory |
| rd_addr | input | AW | Read address |
| rd_ready | output | 1 | No read is held |
| rd_hit | output | 1 | Read line matches a parked eviction or fill |
| mem_ready | input | 1 | Memory bus free this cycle |
| mem_valid | output | 1 | Request offered to memory |
| mem_kind | output | 2 | 0 read, 1 eviction, 2 line fill, 3 posted write |
| mem_addr | output | AW | Request address |
| mem_be | output | BEW | Request byte enables |
| lb_rd | input | 1 | Local bus read miss |
| lb_wr | input | 1 | Local bus write miss |
| lb_owned_proto | input | 1 | Cache runs a protocol with an owned state |
| lb_intv | input | 1 | Another cache intervenes |
| lb_mod | input | 1 | Line status is Modified |
| cyc_wb | output | 1 | Write-back cycle |
| cyc_lf | output | 1 | Line-feed cycle |
| cyc_o3 | output | 1 | Owned-status indication |

## Verification
The bench aims at the following corner cases.

Two partial writes to one address, which must merge. An overlapping repeat and a disjoint write to a new address, which must each take an entry. A design that mixes these up drains the wrong number of writes, or the wrong enables.

A queue filled to capacity, which must drop `cpu_wr_ready`. Reads aimed at offsets inside parked eviction and fill lines, which must hit and never appear on the memory bus.

A read arriving while the bus is busy, which must be held and later issued ahead of every other request. A read arriving together with a pending write on a free bus, which must go first. An arbiter with a wrong priority reorders the scoreboard's stream.

All 32 status combinations, for the cycle decode.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    KIND_RD    = 2'd0,
    KIND_EVICT = 2'd1,
    KIND_FILL  = 2'd2,
    KIND_POST  = 2'd3
  } mem_kind_e;
endpackage

// File: rtl/swb_post_fifo.sv
module swb_post_fifo #(
  parameter int AW    = 32,
  parameter int BEW   = 4,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_valid,
  input  logic [AW-1:0]  push_addr,
  input  logic [BEW-1:0] push_be,
  output logic           push_ready,
  input  logic           pop,
  output logic           head_valid,
  output logic [AW-1:0]  head_addr,
  output logic [BEW-1:0] head_be
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0]  q_addr [DEPTH];
  logic [BEW-1:0] q_be   [DEPTH];
  logic [PW-1:0]  wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx, last_ptr;
  logic [CW-1:0]  count, count_nx;
  logic           full, do_pop, do_merge, do_alloc;

  assign full       = (count == CW'(DEPTH));
  assign push_ready = !full;
  assign head_valid = (count != '0);
  assign head_addr  = q_addr[rd_ptr];
  assign head_be    = q_be[rd_ptr];
  assign last_ptr   = wr_ptr - PW'(1);
  assign do_pop     = pop && head_valid;

  always_comb begin
    do_merge = push_valid && push_ready && (count != '0)
            && (q_addr[last_ptr] == push_addr)
            && ((q_be[last_ptr] & push_be) == '0)
            && !(do_pop && (count == CW'(1)));
    do_alloc = push_valid && push_ready && !do_merge;
    wr_ptr_nx = do_alloc ? wr_ptr + PW'(1) : wr_ptr;
    rd_ptr_nx = do_pop   ? rd_ptr + PW'(1) : rd_ptr;
    count_nx  = count + CW'(do_alloc) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_alloc && (wr_ptr == PW'(i))) begin
        q_addr[i] <= push_addr;
        q_be[i]   <= push_be;
      end else if (do_merge && (last_ptr == PW'(i))) begin
        q_be[i]   <= q_be[i] | push_be;
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_merge_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (do_merge && !do_pop) |=> (count == $past(count)));
  a_r4_alloc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (do_alloc && !do_pop) |=> (count == $past(count) + CW'(1)));
endmodule

// File: rtl/swb_line_slot.sv
module swb_line_slot #(
  parameter int AW    = 32,
  parameter int OFF_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  output logic          ready,
  input  logic          clear,
  output logic          held,
  output logic [AW-OFF_W-1:0] line
);
  localparam int LW = AW - OFF_W;

  logic          held_nx;
  logic [LW-1:0] line_nx;
  logic          take;

  assign ready = !held;
  assign take  = load && !held;

  always_comb begin
    held_nx = held;
    line_nx = line;
    if (take) begin
      held_nx = 1'b1;
      line_nx = load_addr[AW-1:OFF_W];
    end else if (clear) begin
      held_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_nx;
  end

  always_ff @(posedge clk) begin
    if (take) line <= line_nx;
  end

  a_r6_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clear) |=> (held && $stable(line)));
endmodule

// File: rtl/swb_cycle_decode.sv
module swb_cycle_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic wr,
  input  logic owned_proto,
  input  logic intv,
  input  logic modified,
  output logic wb,
  output logic lf,
  output logic o3
);
  logic rd_owned_intv;

  assign rd_owned_intv = rd && owned_proto && intv;
  assign o3 = rd_owned_intv;
  assign lf = intv;
  assign wb = rd_owned_intv || (wr && modified);

  a_r10_o3_implies_wb_lf: assert property (@(posedge clk) disable iff (!rst_n)
    o3 |-> (wb && lf));
endmodule

// File: rtl/snoop_post_addr_buf.sv
module snoop_post_addr_buf
  import swb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BEW   = 4,
  parameter int DEPTH = 4,
  parameter int OFF_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_wr_valid,
  input  logic [AW-1:0]  cpu_wr_addr,
  input  logic [BEW-1:0] cpu_wr_be,
  output logic           cpu_wr_ready,
  input  logic           evict_load,
  input  logic [AW-1:0]  evict_addr,
  output logic           evict_ready,
  input  logic           fill_load,
  input  logic [AW-1:0]  fill_addr,
  output logic           fill_ready,
  input  logic           rd_req,
  input  logic [AW-1:0]  rd_addr,
  output logic           rd_ready,
  output logic           rd_hit,
  input  logic           mem_ready,
  output logic           mem_valid,
  output logic [1:0]     mem_kind,
  output logic [AW-1:0]  mem_addr,
  output logic [BEW-1:0] mem_be,
  input  logic           lb_rd,
  input  logic           lb_wr,
  input  logic           lb_owned_proto,
  input  logic           lb_intv,
  input  logic           lb_mod,
  output logic           cyc_wb,
  output logic           cyc_lf,
  output logic           cyc_o3
);
  localparam int LW = AW - OFF_W;

  logic          ev_held, fl_held, ev_clear, fl_clear;
  logic [LW-1:0] ev_line, fl_line, rd_line;
  logic          head_valid, post_pop;
  logic [AW-1:0] head_addr;
  logic [BEW-1:0] head_be;
  logic          hold_v, hold_v_nx;
  logic [AW-1:0] hold_addr, hold_addr_nx;
  logic          rd_take, rd_snoop_match, rd_new, fire;
  mem_kind_e     sel;

  swb_post_fifo #(.AW(AW), .BEW(BEW), .DEPTH(DEPTH)) u_post (
    .clk, .rst_n,
    .push_valid (cpu_wr_valid),
    .push_addr  (cpu_wr_addr),
    .push_be    (cpu_wr_be),
    .push_ready (cpu_wr_ready),
    .pop        (post_pop),
    .head_valid (head_valid),
    .head_addr  (head_addr),
    .head_be    (head_be)
  );

  swb_line_slot #(.AW(AW), .OFF_W(OFF_W)) u_evict (
    .clk, .rst_n,
    .load (evict_load), .load_addr (evict_addr), .ready (evict_ready),
    .clear (ev_clear), .held (ev_held), .line (ev_line)
  );

  swb_line_slot #(.AW(AW), .OFF_W(OFF_W)) u_fill (
    .clk, .rst_n,
    .load (fill_load), .load_addr (fill_addr), .ready (fill_ready),
    .clear (fl_clear), .held (fl_held), .line (fl_line)
  );

  swb_cycle_decode u_dec (
    .clk, .rst_n,
    .rd (lb_rd), .wr (lb_wr), .owned_proto (lb_owned_proto),
    .intv (lb_intv), .modified (lb_mod),
    .wb (cyc_wb), .lf (cyc_lf), .o3 (cyc_o3)
  );

  // Snoop of an incoming read against the parked line addresses
  assign rd_line        = rd_addr[AW-1:OFF_W];
  assign rd_ready       = !hold_v;
  assign rd_take        = rd_req && rd_ready;
  assign rd_snoop_match = (ev_held && (ev_line == rd_line))
                       || (fl_held && (fl_line == rd_line));
  assign rd_hit         = rd_take && rd_snoop_match;
  assign rd_new         = rd_take && !rd_snoop_match;

  // Fixed-priority bus selection
  always_comb begin
    mem_valid = 1'b1;
    sel       = KIND_POST;
    mem_addr  = head_addr;
    mem_be    = head_be;
    if (hold_v) begin
      sel = KIND_RD;   mem_addr = hold_addr;          mem_be = '1;
    end else if (rd_new) begin
      sel = KIND_RD;   mem_addr = rd_addr;            mem_be = '1;
    end else if (ev_held) begin
      sel = KIND_EVICT; mem_addr = {ev_line, {OFF_W{1'b0}}}; mem_be = '1;
    end else if (fl_held) begin
      sel = KIND_FILL;  mem_addr = {fl_line, {OFF_W{1'b0}}}; mem_be = '1;
    end else if (!head_valid) begin
      mem_valid = 1'b0;
    end
  end

  assign mem_kind = sel;
  assign fire     = mem_valid && mem_ready;
  assign ev_clear = fire && (sel == KIND_EVICT);
  assign fl_clear = fire && (sel == KIND_FILL);
  assign post_pop = fire && (sel == KIND_POST);

  always_comb begin
    hold_v_nx    = hold_v;
    hold_addr_nx = hold_addr;
    if (hold_v && fire) begin
      hold_v_nx = 1'b0;
    end else if (rd_new && !fire) begin
      hold_v_nx    = 1'b1;
      hold_addr_nx = rd_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v <= 1'b0;
    else        hold_v <= hold_v_nx;
  end

  always_ff @(posedge clk) begin
    if (rd_new && !fire) hold_addr <= hold_addr_nx;
  end

  a_r7_held_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> (mem_valid && (mem_kind == 2'd0)));
  a_r8_hold_until_free: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !mem_ready) |=> (hold_v && $stable(hold_addr)));
  a_r9_hit_not_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_ready);
  a_r6_one_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_clear && fl_clear));
endmodule

// File: tb/snoop_post_addr_buf_tb.sv
module snoop_post_addr_buf_tb;
  localparam int AW = 32, BEW = 4;

  typedef struct packed {
    logic [1:0]     kind;
    logic [AW-1:0]  addr;
    logic [BEW-1:0] be;
  } txn_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr_valid = 0, evict_load = 0, fill_load = 0, rd_req = 0, mem_ready = 0;
  logic [AW-1:0] cpu_wr_addr = '0, evict_addr = '0, fill_addr = '0, rd_addr = '0;
  logic [BEW-1:0] cpu_wr_be = '0;
  logic lb_rd = 0, lb_wr = 0, lb_owned_proto = 0, lb_intv = 0, lb_mod = 0;
  logic cpu_wr_ready, evict_ready, fill_ready, rd_ready, rd_hit, mem_valid;
  logic [1:0] mem_kind;
  logic [AW-1:0] mem_addr;
  logic [BEW-1:0] mem_be;
  logic cyc_wb, cyc_lf, cyc_o3;

  int checks = 0, fails = 0;
  txn_t expq[$];

  always #5 clk = ~clk;

  snoop_post_addr_buf u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every accepted bus request must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R2/R7", "unexpected request", {mem_kind, mem_addr}, 0);
      end else begin
        txn_t e;
        e = expq.pop_front();
        chk({mem_kind, mem_addr, mem_be} == e, "R2/R6/R7/R8", "bus request",
            {mem_kind, mem_addr, mem_be}, e);
      end
    end
  end

  task automatic post_wr(input logic [AW-1:0] a, input logic [BEW-1:0] b);
    @(posedge clk); #1;
    cpu_wr_valid = 1; cpu_wr_addr = a; cpu_wr_be = b;
    @(negedge clk);
    while (!cpu_wr_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_wr_valid = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mem_valid == 0, "R1", "mem_valid", mem_valid, 0);
    chk({cpu_wr_ready, rd_ready, evict_ready, fill_ready} == 4'hF, "R1", "readies",
        {cpu_wr_ready, rd_ready, evict_ready, fill_ready}, 4'hF);

    // Bus busy: build queue contents
    post_wr(32'h100, 4'b0011);
    post_wr(32'h100, 4'b1100);   // R3 merge -> 1111
    post_wr(32'h200, 4'b0001);   // R4 new address
    post_wr(32'h200, 4'b0001);   // R4 overlap -> new entry
    post_wr(32'h300, 4'b1110);   // R4 disjoint enables, new address
    @(negedge clk);
    chk(cpu_wr_ready == 0, "R5", "ready when full", cpu_wr_ready, 0);

    // R6 park eviction and fill
    @(posedge clk); #1;
    evict_load = 1; evict_addr = 32'h1234; fill_load = 1; fill_addr = 32'h2040;
    @(posedge clk); #1;
    evict_load = 0; fill_load = 0;
    @(negedge clk);
    chk(evict_ready == 0, "R6", "evict_ready held", evict_ready, 0);
    chk(fill_ready == 0, "R6", "fill_ready held", fill_ready, 0);

    // R9 snoop hits
    @(posedge clk); #1; rd_req = 1; rd_addr = 32'h123C;
    @(negedge clk); chk(rd_hit == 1, "R9", "hit on eviction line", rd_hit, 1);
    @(posedge clk); #1; rd_addr = 32'h205C;
    @(negedge clk); chk(rd_hit == 1, "R9", "hit on fill line", rd_hit, 1);
    @(posedge clk); #1; rd_addr = 32'h3000;
    @(negedge clk); chk(rd_hit == 0, "R9", "no hit elsewhere", rd_hit, 0);
    @(posedge clk); #1; rd_req = 0;
    @(negedge clk); chk(rd_ready == 0, "R8", "read held while busy", rd_ready, 0);

    // Expected drain order (R7): read, evict, fill, posted writes in order (R2)
    expq.push_back('{2'd0, 32'h3000, 4'hF});
    expq.push_back('{2'd1, 32'h1220, 4'hF});
    expq.push_back('{2'd2, 32'h2040, 4'hF});
    expq.push_back('{2'd3, 32'h100, 4'b1111});
    expq.push_back('{2'd3, 32'h200, 4'b0001});
    expq.push_back('{2'd3, 32'h200, 4'b0001});
    expq.push_back('{2'd3, 32'h300, 4'b1110});
    @(posedge clk); #1 mem_ready = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R2", "queue drained", expq.size(), 0);
    chk({rd_ready, evict_ready, fill_ready, cpu_wr_ready} == 4'hF, "R6", "stores free",
        {rd_ready, evict_ready, fill_ready, cpu_wr_ready}, 4'hF);

    // R8 direct read on a free bus, same cycle
    expq.push_back('{2'd0, 32'h4444, 4'hF});
    @(posedge clk); #1; rd_req = 1; rd_addr = 32'h4444;
    @(negedge clk); chk(mem_valid && mem_kind == 2'd0, "R8", "direct read", mem_kind, 0);
    @(posedge clk); #1; rd_req = 0;

    // R7 new read beats a pending posted write; R9 read after drain no longer hits
    mem_ready = 0;
    post_wr(32'h500, 4'b0101);
    expq.push_back('{2'd0, 32'h1230, 4'hF});
    expq.push_back('{2'd3, 32'h500, 4'b0101});
    @(posedge clk); #1; mem_ready = 1; rd_req = 1; rd_addr = 32'h1230;
    @(negedge clk); chk(rd_hit == 0, "R9", "no hit after eviction issued", rd_hit, 0);
    @(posedge clk); #1; rd_req = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R7", "read before write", expq.size(), 0);

    // R10 cycle decode, all combinations
    for (int v = 0; v < 32; v++) begin
      logic e_wb, e_lf, e_o3;
      @(posedge clk); #1;
      {lb_rd, lb_wr, lb_owned_proto, lb_intv, lb_mod} = 5'(v);
      e_o3 = lb_rd & lb_owned_proto & lb_intv;
      e_lf = lb_intv;
      e_wb = e_o3 | (lb_wr & lb_mod);
      @(negedge clk);
      chk({cyc_wb, cyc_lf, cyc_o3} == {e_wb, e_lf, e_o3}, "R10", "cycle decode",
          {cyc_wb, cyc_lf, cyc_o3}, {e_wb, e_lf, e_o3});
    end
    finish_run();
  end
endmodule